// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block gives two independent requesters a set of eight one-bit locks, called tokens, that they can use to share resources. A port asks for a token by writing a zero to it. It gives the token back, or withdraws a request it is still waiting on, by writing a one. It reads the token to find out whether it holds it.

Each token keeps the current owner and also remembers a waiting request from each side. When the holder gives a token back and the other side is waiting, ownership passes to the waiting side in the same cycle. Because of this the two ports never see the same shared bit: the holder reads 0, and the other port reads 1.

The block is synchronous to one clock. Every input is sampled on the rising edge. A read result appears in a per-port output register one cycle after the read cycle and stays there until the next legal read on that port.

Top module: `dsem_bank`

## Requirements
- R1: After reset every token is free, no request is waiting, and both read buses show all ones.
- R2: A token is chosen by the low three address bits (`addr[2:0]`). Address bits above these have no effect on which token is read or written.
- R3: A write (select high, memory select low, `wr`=1) looks only at `wdata[0]`. A value of 0 is a request and a value of 1 is a release or a cancel. All other write data bits are ignored.
- R4: A free token reads 1 on both ports. A held token reads 0 on the holder's port and 1 on the other port. The two ports never both read 0 for the same token.
- R5: A request from the port that does not hold a token does not change what either port reads. A request from the holder also changes nothing.
- R6: When the holder releases a token and the other port has a waiting request, the other port owns the token in the next cycle. With no waiting request, the token becomes free.
- R7: If both ports request the same free token in the same cycle, the left port gets it and the right port's request stays waiting.
- R8: A legal read (select high, memory select low, `oe`=1, `wr`=0) loads the token value into every bit of that port's read register one cycle later. The value loaded is the state before any write made in the same cycle. The register holds its value in every cycle without a legal read.
- R9: A cycle where a port drives its semaphore select and its memory select high together is ignored. It performs no write and leaves the read register unchanged.
- R10: A write of 1 by a port that does not hold the token clears only that port's own waiting request. The holder and the other port's waiting request are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sem_sel | input | 1 | Left semaphore select, active high |
| l_mem_sel | input | 1 | Left memory select, active high; must be low for a semaphore access |
| l_addr | input | ADDR_W | Left address; the low three bits pick the token |
| l_wr | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable for reads |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left read register, token value on every bit |
| r_sem_sel | input | 1 | Right semaphore select, active high |
| r_mem_sel | input | 1 | Right memory select, active high |
| r_addr | input | ADDR_W | Right address |
| r_wr | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_wdata | input | DATA_W | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right read register |

## Verification
Two pairs of functions can land in the same cycle: a request from each port on the same free token, and a read on one port while the other port writes the same token. The bench drives both cases in one cycle. For the first, it checks afterwards that the left port reads 0, and that the right port gains the token as soon as the left port releases it. For the second, it checks that the reader's register shows the state from before the write. It then reads again to confirm the write did take effect.

// File: rtl/dsem_pkg.sv
package dsem_pkg;
  typedef enum logic [1:0] {
    TOK_FREE  = 2'd0,
    TOK_LEFT  = 2'd1,
    TOK_RIGHT = 2'd2
  } tok_own_e;
endpackage

// File: rtl/dsem_port_dec.sv
// Per-port access decode: legality, token index, one-hot request/release.
module dsem_port_dec #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              sem_sel,
  input  logic              mem_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              oe,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_SEM-1:0] req_vec,
  output logic [NUM_SEM-1:0] rel_vec,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx
);
  logic legal;
  logic do_wr;
  logic [IDX_W-1:0] idx;
  logic unused_bits;

  assign legal  = sem_sel & ~mem_sel;
  assign do_wr  = legal & wr;
  assign idx    = addr[IDX_W-1:0];
  assign rd_en  = legal & ~wr & oe;
  assign rd_idx = idx;
  assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_hit
    assign req_vec[i] = do_wr & ~wdata[0] & (idx == IDX_W'(i));
    assign rel_vec[i] = do_wr &  wdata[0] & (idx == IDX_W'(i));
  end
endmodule

// File: rtl/dsem_token.sv
// One token: owner plus a waiting request per side.
module dsem_token
  import dsem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic held_l,
  output logic held_r
);
  tok_own_e own_q, own_d;
  logic pend_l_q, pend_l_d;
  logic pend_r_q, pend_r_d;
  logic want_l, want_r;
  logic upd_en;

  assign want_l = (pend_l_q | l_req) & ~l_rel;
  assign want_r = (pend_r_q | r_req) & ~r_rel;
  assign upd_en = l_req | l_rel | r_req | r_rel;

  always_comb begin
    own_d    = own_q;
    pend_l_d = want_l;
    pend_r_d = want_r;
    unique case (own_q)
      TOK_FREE: begin
        if (want_l) begin
          own_d    = TOK_LEFT;
          pend_l_d = 1'b0;
        end else if (want_r) begin
          own_d    = TOK_RIGHT;
          pend_r_d = 1'b0;
        end
      end
      TOK_LEFT: begin
        pend_l_d = 1'b0;
        if (l_rel) begin
          if (want_r) begin
            own_d    = TOK_RIGHT;
            pend_r_d = 1'b0;
          end else begin
            own_d = TOK_FREE;
          end
        end
      end
      TOK_RIGHT: begin
        pend_r_d = 1'b0;
        if (r_rel) begin
          if (want_l) begin
            own_d    = TOK_LEFT;
            pend_l_d = 1'b0;
          end else begin
            own_d = TOK_FREE;
          end
        end
      end
      default: begin
        own_d    = TOK_FREE;
        pend_l_d = 1'b0;
        pend_r_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= TOK_FREE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else if (upd_en) begin
      own_q    <= own_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign held_l = (own_q == TOK_LEFT);
  assign held_r = (own_q == TOK_RIGHT);
endmodule

// File: rtl/dsem_rd_reg.sv
// Per-port read register: token value replicated across the bus.
module dsem_rd_reg #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [NUM_SEM-1:0] held_vec,
  output logic [DATA_W-1:0]  rdata
);
  logic tok_bit;
  logic [DATA_W-1:0] rdata_d;

  assign tok_bit = ~held_vec[rd_idx];
  assign rdata_d = {DATA_W{tok_bit}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '1;
    else if (rd_en) rdata <= rdata_d;
  end
endmodule

// File: rtl/dsem_bank.sv
module dsem_bank #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sem_sel,
  input  logic              l_mem_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem_sel,
  input  logic              r_mem_sel,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_SEM-1:0] held_l, held_r;
  logic l_rd_en, r_rd_en;
  logic [IDX_W-1:0] l_rd_idx, r_rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dsem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
    .sem_sel(l_sem_sel), .mem_sel(l_mem_sel), .addr(l_addr), .wr(l_wr),
    .oe(l_oe), .wdata(l_wdata), .req_vec(l_req), .rel_vec(l_rel),
    .rd_en(l_rd_en), .rd_idx(l_rd_idx)
  );

  dsem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
    .sem_sel(r_sem_sel), .mem_sel(r_mem_sel), .addr(r_addr), .wr(r_wr),
    .oe(r_oe), .wdata(r_wdata), .req_vec(r_req), .rel_vec(r_rel),
    .rd_en(r_rd_en), .rd_idx(r_rd_idx)
  );

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_tok
    dsem_token u_tok (
      .clk(clk), .rst_n(rst_int_n),
      .l_req(l_req[i]), .l_rel(l_rel[i]),
      .r_req(r_req[i]), .r_rel(r_rel[i]),
      .held_l(held_l[i]), .held_r(held_r[i])
    );
  end

  dsem_rd_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst_n(rst_int_n), .rd_en(l_rd_en), .rd_idx(l_rd_idx),
    .held_vec(held_l), .rdata(l_rdata)
  );

  dsem_rd_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst_n(rst_int_n), .rd_en(r_rd_en), .rd_idx(r_rd_idx),
    .held_vec(held_r), .rdata(r_rdata)
  );
endmodule

// File: rtl/dsem_bank_chk.sv
module dsem_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_sem_sel,
  input logic              l_mem_sel,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_wr,
  input logic              l_oe,
  input logic [DATA_W-1:0] l_wdata,
  input logic [DATA_W-1:0] l_rdata,
  input logic              r_sem_sel,
  input logic              r_mem_sel,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_wr,
  input logic              r_oe,
  input logic [DATA_W-1:0] r_wdata,
  input logic [DATA_W-1:0] r_rdata
);
  logic l_rd, r_rd, same_tok;
  logic unused_chk;
  assign l_rd = l_sem_sel & ~l_mem_sel & l_oe & ~l_wr;
  assign r_rd = r_sem_sel & ~r_mem_sel & r_oe & ~r_wr;
  assign same_tok = (l_addr[IDX_W-1:0] == r_addr[IDX_W-1:0]);
  assign unused_chk = ^{l_wdata, r_wdata};

  AST_L_RD_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(l_rdata) == 0) || ($countones(l_rdata) == DATA_W)); // R8
  AST_R_RD_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(r_rdata) == 0) || ($countones(r_rdata) == DATA_W)); // R8
  AST_L_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> $stable(l_rdata)); // R8
  AST_R_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd |=> $stable(r_rdata)); // R8
  AST_L_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sem_sel && l_mem_sel) |=> $stable(l_rdata)); // R9
  AST_R_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (r_sem_sel && r_mem_sel) |=> $stable(r_rdata)); // R9
  AST_NO_DUAL_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd && r_rd && same_tok) |=> !(l_rdata[0] == 1'b0 && r_rdata[0] == 1'b0)); // R4
endmodule

bind dsem_bank dsem_bank_chk #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dsem_bank_bench.sv
module dsem_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sem_sel = 0, l_mem_sel = 0, l_wr = 0, l_oe = 0;
  logic r_sem_sel = 0, r_mem_sel = 0, r_wr = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;

  int checks = 0;
  int errors = 0;
  int own [8];
  bit pl [8];
  bit pr [8];
  logic [DW-1:0] exp_l = '1, exp_r = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsem_bank u_dsem_bank (
    .clk(clk), .rst_n(rst_n),
    .l_sem_sel(l_sem_sel), .l_mem_sel(l_mem_sel), .l_addr(l_addr), .l_wr(l_wr),
    .l_oe(l_oe), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_sel(r_sem_sel), .r_mem_sel(r_mem_sel), .r_addr(r_addr), .r_wr(r_wr),
    .r_oe(r_oe), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  // op: 0 idle, 1 read, 2 write 0, 3 write 1, 4 illegal write 0, 5 illegal read
  task automatic set_l(input int op, input int idx, input logic [AW-1:0] hi);
    l_sem_sel = (op != 0);
    l_mem_sel = (op >= 4);
    l_wr      = (op == 2 || op == 3 || op == 4);
    l_oe      = (op == 1 || op == 5);
    l_addr    = (hi & ~AW'(7)) | AW'(idx);
    l_wdata   = (op == 3) ? DW'(16'h0001) : DW'(16'hFFFE);
  endtask

  task automatic set_r(input int op, input int idx, input logic [AW-1:0] hi);
    r_sem_sel = (op != 0);
    r_mem_sel = (op >= 4);
    r_wr      = (op == 2 || op == 3 || op == 4);
    r_oe      = (op == 1 || op == 5);
    r_addr    = (hi & ~AW'(7)) | AW'(idx);
    r_wdata   = (op == 3) ? DW'(16'h0001) : DW'(16'hFFFE);
  endtask

  task automatic model_step();
    bit lok, rok;
    int li, ri;
    lok = l_sem_sel && !l_mem_sel;
    rok = r_sem_sel && !r_mem_sel;
    li = int'(l_addr[2:0]);
    ri = int'(r_addr[2:0]);
    if (lok && !l_wr && l_oe) exp_l = (own[li] == 1) ? '0 : '1;
    if (rok && !r_wr && r_oe) exp_r = (own[ri] == 2) ? '0 : '1;
    for (int k = 0; k < 8; k++) begin
      bit lq, lr, rq, rr, wl, wr_;
      lq = lok && l_wr && (li == k) && !l_wdata[0];
      lr = lok && l_wr && (li == k) &&  l_wdata[0];
      rq = rok && r_wr && (ri == k) && !r_wdata[0];
      rr = rok && r_wr && (ri == k) &&  r_wdata[0];
      wl  = (pl[k] || lq) && !lr;
      wr_ = (pr[k] || rq) && !rr;
      if (own[k] == 0) begin
        if (wl)       begin own[k] = 1; pl[k] = 0; pr[k] = wr_; end
        else if (wr_) begin own[k] = 2; pr[k] = 0; pl[k] = 0; end
      end else if (own[k] == 1) begin
        pl[k] = 0;
        if (lr) begin own[k] = wr_ ? 2 : 0; pr[k] = 0; end
        else pr[k] = wr_;
      end else begin
        pr[k] = 0;
        if (rr) begin own[k] = wl ? 1 : 0; pl[k] = 0; end
        else pl[k] = wl;
      end
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    checks++;
    if (l_rdata !== exp_l) begin
      errors++;
      $display("FAIL %s left rdata actual %h expected %h", tag, l_rdata, exp_l);
    end
    checks++;
    if (r_rdata !== exp_r) begin
      errors++;
      $display("FAIL %s right rdata actual %h expected %h", tag, r_rdata, exp_r);
    end
  endtask

  task automatic both_read(input int idx, input string tag);
    set_l(1, idx, 16'h0000); set_r(1, idx, 16'h0000); tick(tag);
    set_l(0, 0, 0); set_r(0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) begin own[k] = 0; pl[k] = 0; pr[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tick("R1 reset state");
    for (int k = 0; k < 8; k++) both_read(k, "R1 all tokens free");

    // R3/R4: take, then read from both sides
    set_l(2, 3, 16'h0000); tick("R3 left request");
    set_l(0, 0, 0);
    both_read(3, "R4 holder 0 other 1");
    // R5: non-holder request is pending, invisible
    set_r(2, 3, 16'h0000); tick("R5 right request on held");
    set_r(0, 0, 0);
    both_read(3, "R5 reads unchanged");
    set_l(2, 3, 16'h0000); tick("R5 holder re-request");
    set_l(0, 0, 0);
    both_read(3, "R5 holder re-request no change");
    // R6: release hands over
    set_l(3, 3, 16'h0000); tick("R6 release with waiter");
    set_l(0, 0, 0);
    both_read(3, "R6 ownership moved right");
    set_r(3, 3, 16'h0000); tick("R6 release no waiter");
    set_r(0, 0, 0);
    both_read(3, "R6 token free");
    set_r(3, 3, 16'h0000); tick("R3 release of free token");
    set_r(0, 0, 0);
    both_read(3, "R3 free stays free");

    // R2: upper address bits ignored
    set_l(2, 5, 16'hABC0); tick("R2 request high bits set");
    set_l(0, 0, 0);
    set_l(1, 5, 16'h5430); set_r(1, 4, 16'hFFF8); tick("R2 read other high bits");
    set_l(0, 0, 0); set_r(0, 0, 0);
    set_r(1, 5, 16'h1238); tick("R2 right sees held");
    set_r(0, 0, 0);

    // R7: same-cycle tie
    set_l(2, 2, 0); set_r(2, 2, 0); tick("R7 tie");
    set_l(0, 0, 0); set_r(0, 0, 0);
    both_read(2, "R7 left wins");
    set_l(3, 2, 0); tick("R7 left release");
    set_l(0, 0, 0);
    both_read(2, "R7 right request stayed pending");
    set_r(3, 2, 0); tick("R7 right release");
    set_r(0, 0, 0);
    both_read(2, "R7 free again");

    // R10: cancel only own request
    set_l(2, 6, 0); tick("R10 left take");
    set_r(2, 6, 0); set_l(0, 0, 0); tick("R10 right waits");
    set_r(3, 6, 0); tick("R10 right cancels");
    set_r(0, 0, 0);
    both_read(6, "R10 holder unchanged");
    set_l(3, 6, 0); tick("R10 left release");
    set_l(0, 0, 0);
    both_read(6, "R10 token free after cancel");
    set_r(2, 1, 0); tick("R10 right take");
    set_l(2, 1, 0); set_r(0, 0, 0); tick("R10 left waits");
    set_r(3, 7, 0); tick("R10 right cancel other token");
    set_r(3, 1, 0); set_l(0, 0, 0); tick("R10 right release");
    set_r(0, 0, 0);
    both_read(1, "R10 left request survived");
    set_l(3, 1, 0); tick("R10 left release token1");
    set_l(0, 0, 0);

    // R8: read captures pre-write state
    set_l(2, 4, 0); set_r(1, 4, 0); tick("R8 read during other write");
    set_l(0, 0, 0); set_r(0, 0, 0);
    tick("R8 register holds");
    both_read(4, "R8 write took effect");
    set_r(2, 4, 0); set_l(1, 4, 0); tick("R8 right request during left read");
    set_l(0, 0, 0); set_r(0, 0, 0);
    set_l(3, 4, 0); set_r(1, 4, 0); tick("R8 release during right read");
    set_l(0, 0, 0); set_r(0, 0, 0);
    both_read(4, "R8 right now holds");
    set_r(3, 4, 0); tick("R8 cleanup");
    set_r(0, 0, 0);

    // R9: illegal select combination
    set_l(4, 0, 0); tick("R9 illegal write");
    set_l(0, 0, 0);
    both_read(0, "R9 illegal write ignored");
    set_l(1, 5, 0); tick("R9 left reads held token");
    set_l(5, 0, 0); tick("R9 illegal read holds");
    set_r(4, 0, 0); set_l(0, 0, 0); tick("R9 right illegal write");
    set_r(5, 0, 0); tick("R9 right illegal read");
    set_r(0, 0, 0);
    both_read(0, "R9 token0 still free");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule